// File: doc/BRIEF.md
# Key-Locked Parallel Segment Insertion Cell

This block is one insertion point of a multi-lane scan network. Each of its lanes carries a one-bit insertion cell followed by a short run of key cells. A single shared select register decides whether the hosted segments are spliced in front of the insertion cells of every lane. Opening the block makes every lane longer by the length of its hosted segment, so the path from scan input to scan output grows. Only that change in length shows from outside that the block was unlocked.

The select register loads only on an update that happens while the unlock term is true. The unlock term is an AND/NOT tree over a fixed set of key positions spread across the lanes. Each position is compared with a fixed expected bit. Positions outside the mask are ignored.

A parameter picks where the tree reads its inputs. In the default variant it reads the key cells in the shift path. The key and the open bit then travel in one scan, and one update opens the block. In the other variant, added key update registers latch the key cells on every update and the tree reads those registers. The key must then be loaded one scan ahead, and the hosted segment is first reachable on the third scan. A second parameter makes the key cells clear on capture.

Top module: `lkpar_sib`

## Requirements
- R1: While reset is active and right after it, `select` is 0, `unlocked` is 0 for a key whose masked expected bits are not all zero, and every `scan_out` lane is 0. In the two-scan variant, reset also clears the key update registers.
- R2: When closed, each lane runs from `scan_in` through the insertion cell and then KEY_DEPTH key cells to `scan_out`. A bit shifted in appears at `scan_out` after KEY_DEPTH+1 shift edges.
- R3: When open, each lane feeds `seg_ret` into the insertion cell instead of `scan_in`. The path from `scan_in` through an external segment of S cells therefore takes S+KEY_DEPTH+1 shift edges.
- R4: On capture, every insertion cell loads the current `select`. Capture takes priority over shift.
- R5: With KEY_CLEAR_ON_CAPTURE set, capture clears all key cells. A key shifted in earlier is lost, and an update after that capture does not change `select`.
- R6: Key cell d of lane l (d = 0 next to the insertion cell) is key index l*KEY_DEPTH+d. `unlocked` is 1 exactly when every index whose KEY_MASK bit is 1 equals the matching KEY_VALUE bit. Indices whose mask bit is 0 have no effect.
- R7: An update while `unlocked` is 0 leaves `select` unchanged, whether it was open or closed.
- R8: An update while `unlocked` is 1 loads the lane-0 insertion cell into `select`. In the default variant, one scan that carries the correct key and a 1 for lane 0 opens the block.
- R9: With KEY_IN_UPDATE set, every update copies all key cells into key update registers, and `unlocked` is computed from those registers. An update can open the block only if the previous update carried the key.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Scan clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| scan_in | input | LANES | Per-lane scan input; also drives the input of each hosted segment |
| seg_ret | input | LANES | Per-lane return from the hosted segment |
| capture_en | input | 1 | Capture phase enable |
| shift_en | input | 1 | Shift phase enable |
| update_en | input | 1 | Update phase enable |
| scan_out | output | LANES | Per-lane scan output (last key cell) |
| select | output | 1 | Shared segment select; also gates hosted segment shifting outside |
| unlocked | output | 1 | Key comparison result |

## Verification
The bench builds two copies with four lanes, two key cells per lane, an 8-bit mask that leaves three positions free, and hosted segments of three cells. One copy uses the default single-scan variant with key cells cleared on capture. The other uses the two-scan variant. Together they reach a wrong key in a masked position, a key that differs only in unmasked positions, an attempt to close without the key, a key lost to capture, and the one-scan lag of the latched key. Path length is measured in both the closed and open states.

// File: rtl/lkpar_pkg.sv
package lkpar_pkg;

  // Phase decoded by every lane from the three scan enables.
  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_CAPTURE = 2'd1,
    PH_SHIFT   = 2'd2
  } scan_phase_e;

  function automatic scan_phase_e decode_phase(input logic cap, input logic sh);
    if (cap)     return PH_CAPTURE;
    else if (sh) return PH_SHIFT;
    else         return PH_IDLE;
  endfunction

endpackage

// File: rtl/lkpar_rst_sync.sv
module lkpar_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_sync_n = s2_q;
endmodule

// File: rtl/lkpar_lane.sv
module lkpar_lane
  import lkpar_pkg::*;
#(
  parameter int KEY_DEPTH            = 2,
  parameter bit KEY_CLEAR_ON_CAPTURE = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cap_en,
  input  logic                 shift_en,
  input  logic                 sel,
  input  logic                 scan_in,
  input  logic                 seg_ret,
  output logic                 scan_out,
  output logic                 ins_bit,
  output logic [KEY_DEPTH-1:0] key_cells
);
  scan_phase_e          phase;
  logic                 ins_q, ins_d;
  logic [KEY_DEPTH-1:0] key_q, key_d;

  assign phase = decode_phase(cap_en, shift_en);

  always_comb begin
    ins_d = ins_q;
    key_d = key_q;
    case (phase)
      PH_CAPTURE: begin
        ins_d = sel;
        if (KEY_CLEAR_ON_CAPTURE) key_d = '0;
      end
      PH_SHIFT: begin
        ins_d    = sel ? seg_ret : scan_in;
        key_d[0] = ins_q;
        for (int d = 1; d < KEY_DEPTH; d++) key_d[d] = key_q[d-1];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ins_q <= 1'b0;
      key_q <= '0;
    end else begin
      ins_q <= ins_d;
      key_q <= key_d;
    end
  end

  assign scan_out  = key_q[KEY_DEPTH-1];
  assign ins_bit   = ins_q;
  assign key_cells = key_q;

  // R4: insertion cell takes the select value on capture
  assert_capture_sel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> (ins_q == $past(sel)));

  // R2: shifting moves the insertion cell into the first key cell
  assert_shift_chain_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !cap_en) |=> (key_q[0] == $past(ins_q)));

  generate
    if (KEY_CLEAR_ON_CAPTURE) begin : g_clr_chk
      // R5: capture wipes the key cells
      assert_key_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |=> (key_q == '0));
    end
  endgenerate
endmodule

// File: rtl/lkpar_key_logic.sv
module lkpar_key_logic #(
  parameter int            KEY_BITS      = 8,
  parameter logic [KEY_BITS-1:0] KEY_MASK  = '1,
  parameter logic [KEY_BITS-1:0] KEY_VALUE = '0,
  parameter bit            KEY_IN_UPDATE = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                upd_en,
  input  logic [KEY_BITS-1:0] key_shift,
  output logic                unlock
);
  logic [KEY_BITS-1:0] src;
  logic [KEY_BITS-1:0] term;

  generate
    if (KEY_IN_UPDATE) begin : g_latched
      logic [KEY_BITS-1:0] kup_q, kup_d;

      always_comb begin
        kup_d = kup_q;
        if (upd_en) kup_d = key_shift;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) kup_q <= '0;
        else        kup_q <= kup_d;
      end

      assign src = kup_q;

      // R9: every update copies the key cells into the key registers
      assert_key_latch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> (kup_q == $past(key_shift)));
    end else begin : g_direct
      assign src = key_shift;
    end
  endgenerate

  // AND/NOT tree: a term is forced true where the mask is clear
  generate
    for (genvar i = 0; i < KEY_BITS; i++) begin : g_term
      if (!KEY_MASK[i])      begin : g_free assign term[i] = 1'b1;    end
      else if (KEY_VALUE[i]) begin : g_one  assign term[i] = src[i];  end
      else                   begin : g_zero assign term[i] = ~src[i]; end
    end
  endgenerate

  assign unlock = &term;
endmodule

// File: rtl/lkpar_upd_cell.sv
module lkpar_upd_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic upd_en,
  input  logic unlock,
  input  logic open_bit,
  output logic select
);
  logic sel_q, sel_d, load;

  assign load = upd_en & unlock;

  always_comb begin
    sel_d = sel_q;
    if (load) sel_d = open_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= 1'b0;
    else        sel_q <= sel_d;
  end

  assign select = sel_q;

  // R7: a locked update changes nothing
  assert_locked_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !unlock) |=> $stable(sel_q));

  // R8: an unlocked update takes the lane-0 insertion cell
  assert_open_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && unlock) |=> (sel_q == $past(open_bit)));
endmodule

// File: rtl/lkpar_sib.sv
module lkpar_sib #(
  parameter int LANES                = 4,
  parameter int KEY_DEPTH            = 2,
  parameter logic [LANES*KEY_DEPTH-1:0] KEY_MASK  = 8'b1011_0110,
  parameter logic [LANES*KEY_DEPTH-1:0] KEY_VALUE = 8'b1001_0100,
  parameter bit KEY_IN_UPDATE        = 1'b0,
  parameter bit KEY_CLEAR_ON_CAPTURE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] scan_in,
  input  logic [LANES-1:0] seg_ret,
  input  logic             capture_en,
  input  logic             shift_en,
  input  logic             update_en,
  output logic [LANES-1:0] scan_out,
  output logic             select,
  output logic             unlocked
);
  localparam int KEY_BITS = LANES * KEY_DEPTH;

  logic                rst_i_n;
  logic [LANES-1:0]    ins_bits;
  logic [KEY_BITS-1:0] key_bus;
  logic                unlock;
  logic                sel;

  lkpar_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      lkpar_lane #(
        .KEY_DEPTH            (KEY_DEPTH),
        .KEY_CLEAR_ON_CAPTURE (KEY_CLEAR_ON_CAPTURE)
      ) u_lane (
        .clk       (clk),
        .rst_n     (rst_i_n),
        .cap_en    (capture_en),
        .shift_en  (shift_en),
        .sel       (sel),
        .scan_in   (scan_in[l]),
        .seg_ret   (seg_ret[l]),
        .scan_out  (scan_out[l]),
        .ins_bit   (ins_bits[l]),
        .key_cells (key_bus[l*KEY_DEPTH +: KEY_DEPTH])
      );
    end
  endgenerate

  lkpar_key_logic #(
    .KEY_BITS      (KEY_BITS),
    .KEY_MASK      (KEY_MASK),
    .KEY_VALUE     (KEY_VALUE),
    .KEY_IN_UPDATE (KEY_IN_UPDATE)
  ) u_key (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .upd_en    (update_en),
    .key_shift (key_bus),
    .unlock    (unlock)
  );

  lkpar_upd_cell u_upd (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .upd_en   (update_en),
    .unlock   (unlock),
    .open_bit (ins_bits[0]),
    .select   (sel)
  );

  assign select   = sel;
  assign unlocked = unlock;
endmodule

// File: tb/lkpar_sib_bench.sv
module lkpar_sib_bench;
  localparam int L   = 4;
  localparam int D   = 2;
  localparam int J   = L * D;
  localparam int SEG = 3;
  localparam logic [J-1:0] KM = 8'b1011_0110;
  localparam logic [J-1:0] KV = 8'b1001_0100;

  // {key[7:0], lane-0 open bit, expected select, expected unlocked}
  localparam logic [10:0] TBL [8] = '{
    {8'h96, 1'b1, 1'b0, 1'b0},  // wrong masked bit 1: stays closed
    {8'h94, 1'b0, 1'b0, 1'b1},  // right key, open bit 0
    {8'h94, 1'b1, 1'b1, 1'b1},  // right key opens in one scan
    {8'h14, 1'b0, 1'b1, 1'b0},  // wrong key cannot close
    {8'hDD, 1'b0, 1'b0, 1'b1},  // free positions flipped: still unlocks, closes
    {8'hDD, 1'b1, 1'b1, 1'b1},
    {8'h00, 1'b0, 1'b1, 1'b0},
    {8'h94, 1'b0, 1'b0, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic [L-1:0] si;
  logic [1:0] cap_v, sh_v, up_v;
  logic [L-1:0] so0, so1, ret0, ret1;
  logic sel0, sel1, unl0, unl1;
  logic [SEG-1:0] sg0 [L];
  logic [SEG-1:0] sg1 [L];
  logic [1:0] msel;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  lkpar_sib u_lkpar_sib (
    .clk(clk), .rst_n(rst_n), .scan_in(si), .seg_ret(ret0),
    .capture_en(cap_v[0]), .shift_en(sh_v[0]), .update_en(up_v[0]),
    .scan_out(so0), .select(sel0), .unlocked(unl0));

  lkpar_sib #(.KEY_IN_UPDATE(1'b1)) u_lkpar_sib_two (
    .clk(clk), .rst_n(rst_n), .scan_in(si), .seg_ret(ret1),
    .capture_en(cap_v[1]), .shift_en(sh_v[1]), .update_en(up_v[1]),
    .scan_out(so1), .select(sel1), .unlocked(unl1));

  // external hosted segments, shifted only while selected
  always @(posedge clk) begin
    for (int l = 0; l < L; l++) begin
      if (sh_v[0] && sel0) sg0[l] <= {sg0[l][SEG-2:0], si[l]};
      if (sh_v[1] && sel1) sg1[l] <= {sg1[l][SEG-2:0], si[l]};
    end
  end
  always_comb begin
    for (int l = 0; l < L; l++) begin
      ret0[l] = sg0[l][SEG-1];
      ret1[l] = sg1[l][SEG-1];
    end
  end

  task automatic check(input logic [L-1:0] act, input logic [L-1:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic logic [L-1:0] pick_so(input int inst);
    return (inst == 0) ? so0 : so1;
  endfunction

  task automatic pulse_cap(input int inst);
    @(negedge clk); cap_v[inst] = 1'b1;
    @(negedge clk); cap_v[inst] = 1'b0;
  endtask

  task automatic pulse_upd(input int inst);
    @(negedge clk); up_v[inst] = 1'b1;
    @(negedge clk); up_v[inst] = 1'b0;
  endtask

  task automatic do_scan(input int inst, input logic [J-1:0] key,
                         input logic [L-1:0] ins, input bit cap, input bit upd);
    int len;
    len = D + 1 + (msel[inst] ? SEG : 0);
    if (cap) pulse_cap(inst);
    for (int t = 0; t < len; t++) begin
      @(negedge clk);
      if (cap && t == D) check(pick_so(inst), {L{msel[inst]}}, "R4 captured select");
      sh_v[inst] = 1'b1;
      for (int l = 0; l < L; l++)
        si[l] = (t < D) ? key[l*D + D-1-t] : ((t == D) ? ins[l] : 1'b0);
    end
    @(negedge clk);
    sh_v[inst] = 1'b0;
    si = '0;
    if (upd) begin
      up_v[inst] = 1'b1;
      @(negedge clk);
      up_v[inst] = 1'b0;
    end
  endtask

  task automatic latency(input int inst, input int exp_len, input string tag);
    for (int f = 0; f < D + 1 + SEG; f++) begin
      @(negedge clk); sh_v[inst] = 1'b1; si = '0;
    end
    for (int e = 1; e <= exp_len; e++) begin
      @(negedge clk);
      if (e == exp_len) check(pick_so(inst), '0, {tag, " early"});
      sh_v[inst] = 1'b1;
      si = (e == 1) ? '1 : '0;
    end
    @(negedge clk);
    check(pick_so(inst), '1, {tag, " arrival"});
    sh_v[inst] = 1'b0;
    si = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; si = '0; cap_v = '0; sh_v = '0; up_v = '0; msel = '0;
    for (int l = 0; l < L; l++) begin sg0[l] = '0; sg1[l] = '0; end
    repeat (3) @(negedge clk);
    check({sel0, unl0, sel1, unl1}, 4'b0000, "R1 in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(so0, '0, "R1 scan_out after reset");
    check({sel0, unl0, sel1, unl1}, 4'b0000, "R1 after reset");

    // R2 closed path length
    latency(0, D + 1, "R2 closed");

    // table walk on single-scan copy: R6 R7 R8
    for (int i = 0; i < 8; i++) begin
      do_scan(0, TBL[i][10:3], {3'b101, TBL[i][2]}, 1'b1, 1'b1);
      check({3'b000, sel0}, {3'b000, TBL[i][1]}, $sformatf("R7/R8 row %0d select", i));
      check({3'b000, unl0}, {3'b000, TBL[i][0]}, $sformatf("R6 row %0d unlocked", i));
      msel[0] = TBL[i][1];
    end

    // R3 open path length
    do_scan(0, 8'h94, 4'b0001, 1'b1, 1'b1);
    msel[0] = 1'b1;
    check({3'b000, sel0}, 4'b0001, "R8 open again");
    latency(0, SEG + D + 1, "R3 open");
    do_scan(0, 8'h94, 4'b0000, 1'b0, 1'b1);
    msel[0] = 1'b0;
    check({3'b000, sel0}, 4'b0000, "R8 closed after length test");

    // R5 capture destroys the guess
    do_scan(0, 8'h94, 4'b0001, 1'b0, 1'b0);
    check({3'b000, unl0}, 4'b0001, "R6 key visible before capture");
    pulse_cap(0);
    check({3'b000, unl0}, 4'b0000, "R5 key cleared by capture");
    pulse_upd(0);
    check({3'b000, sel0}, 4'b0000, "R5 update after capture stays closed");

    // R9 two-scan variant
    do_scan(1, 8'h94, 4'b0001, 1'b1, 1'b1);
    check({2'b00, sel1, unl1}, 4'b0001, "R9 first scan only loads key");
    do_scan(1, 8'h94, 4'b0001, 1'b1, 1'b1);
    check({2'b00, sel1, unl1}, 4'b0011, "R9 second scan opens");
    msel[1] = 1'b1;
    latency(1, SEG + D + 1, "R3 open two-scan");
    do_scan(1, 8'h96, 4'b0000, 1'b1, 1'b1);
    check({2'b00, sel1, unl1}, 4'b0000, "R9 closes on previously held key");
    msel[1] = 1'b0;
    do_scan(1, 8'h94, 4'b0001, 1'b1, 1'b1);
    check({2'b00, sel1, unl1}, 4'b0001, "R9 open refused after wrong key");

    // R1 reset clears key registers mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check({sel0, unl0, sel1, unl1}, 4'b0000, "R1 reset clears key registers");
    rst_n = 1'b1;
    msel = '0;
    repeat (4) @(negedge clk);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule